// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Selectable Read Latency

The block is a true two-port static memory of 18-bit words. Its two ports, A and B, are identical, each with its own clock and reset. Either port may read or write any location in any cycle, independently of the other. Address, read/write and lane selects are taken on the rising edge of the port clock. A write is committed at that same edge. Each word is split into two 9-bit lanes that are written and driven separately.

Each port picks its read timing with a mode pin. With flow-through timing the word appears in the cycle after its address is taken. With pipelined timing it passes through one more register and appears one cycle later. A port is selected only when its active-low and active-high chip selects are both asserted. The tristate data pins of a port are modelled as a read-data bus plus a per-lane drive-enable vector.

The memory takes a request on every enabled cycle and has no back-pressure. The ports therefore carry no valid/ready handshake: an enabled cycle is the request, and a drive-enable bit marks valid read data.

Top module: `tpram_top`

## Requirements
- R1: Ports A and B run on unrelated clocks. Each can read or write any address at any time. A word written by one port is read back unchanged by either port.
- R2: A word is 18 bits. Lane 0 is bits 8:0 and lane 1 is bits 17:9. `lane_n[0]` selects lane 0 and `lane_n[1]` selects lane 1, both active low. A write changes only the selected lanes.
- R3: `wr_n` low in a selected cycle writes. `wr_n` high reads and leaves the memory unchanged, whatever is on `wdata`.
- R4: `drive[i]` is 1 only for read data on a lane whose select was low in the read cycle, while `oe_n` is low. `oe_n` acts without a clock. A lane whose `drive` bit is 0 shows 0 on `rdata`.
- R5: A port is selected only when `cs_n` = 0 and `cs` = 1. A cycle with any other combination writes nothing and produces no read data.
- R6: With `pipe` = 0, read data and drive enables are valid in the one cycle after the capturing edge. They are then 0 unless another read follows.
- R7: With `pipe` = 1, read data and drive enables are valid one cycle later than with `pipe` = 0. The drive bits are 0 in the cycle after the capturing edge.
- R8: With `pipe` = 1, a deselected cycle turns the outputs off two edges later, even between two reads. The port drives again only for a read taken in an enabled cycle.
- R9: The depth is 2^`ADDR_W` words, with `ADDR_W` = 12 for 4K words or 13 for 8K words. The first and the last address are fully usable.
- R10: Writes by both ports to different addresses in the same cycle both take effect. If both ports write the same address in the same cycle, the stored value is undefined.
- R11: While reset is low, and after it until the first read, `drive` and `rdata` of that port are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_cs | input | 1 | Port A chip select, active high |
| a_wr_n | input | 1 | Port A write when low, read when high |
| a_lane_n | input | 2 | Port A lane selects, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_pipe | input | 1 | Port A timing: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, 0 on lanes not driven |
| a_drive | output | 2 | Port A per-lane drive enable |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_cs | input | 1 | Port B chip select, active high |
| b_wr_n | input | 1 | Port B write when low, read when high |
| b_lane_n | input | 2 | Port B lane selects, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_pipe | input | 1 | Port B timing: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, 0 on lanes not driven |
| b_drive | output | 2 | Port B per-lane drive enable |

## Verification
The bench writes a lower or an upper lane alone, so a design that ignored a lane select would clobber the other lane. Both ports then write interleaved addresses at the same time, up to the last address, and each reads what the other wrote. A write path that let one port overwrite the other's data, or that cut the address short, returns wrong words.

In pipelined mode the bench places a deselected cycle between two reads. It checks that the drive bits are low one cycle early, and low again in the gap. A design with the wrong latency, or one that kept driving stale data after a deselect, is caught there.

Writes with each wrong chip-select combination, and reads carrying junk on the write-data pins, must leave the memory unchanged. This catches a decoder that accepts one of the two enables alone.

// File: rtl/tpram_pkg.sv
package tpram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/tpram_bank.sv
// One storage bank, written only by its owning port. The stored value is
// the written data XOR the peer bank, so the word = bank A ^ bank B.
module tpram_bank
  import tpram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  lane_t             we,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wdata,
  input  logic [ADDR_W-1:0] self_raddr,
  input  logic [ADDR_W-1:0] peer_raddr,
  input  logic [ADDR_W-1:0] peer_waddr,
  output word_t             self_q,
  output word_t             peer_q,
  output word_t             peer_wq
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign self_q[l*LANE_W +: LANE_W]  = mem[self_raddr];
    assign peer_q[l*LANE_W +: LANE_W]  = mem[peer_raddr];
    assign peer_wq[l*LANE_W +: LANE_W] = mem[peer_waddr];
  end
endmodule

// File: rtl/tpram_port.sv
// Port logic: select decode, write encoding, read stages, lane drive.
module tpram_port
  import tpram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              wr_n,
  input  lane_t             lane_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  input  word_t             own_at_rd,
  input  word_t             peer_at_rd,
  input  word_t             peer_at_wr,
  output lane_t             bank_we,
  output logic [ADDR_W-1:0] bank_waddr,
  output word_t             bank_wdata,
  output logic [ADDR_W-1:0] rd_addr,
  output word_t             rdata,
  output lane_t             drive
);
  logic              sel;
  logic              s1_rd, s2_rd;
  lane_t             s1_lanes, s2_lanes;
  logic [ADDR_W-1:0] s1_addr;
  word_t             s2_data;
  word_t             flow_data;
  logic              out_rd;
  lane_t             out_lanes;
  word_t             out_data;

  assign sel        = !cs_n && cs;
  assign bank_we    = (sel && !wr_n) ? ~lane_n : '0;
  assign bank_waddr = addr;
  assign bank_wdata = wdata ^ peer_at_wr;

  assign rd_addr    = s1_addr;
  assign flow_data  = own_at_rd ^ peer_at_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd    <= 1'b0;
      s1_lanes <= '0;
      s1_addr  <= '0;
      s2_rd    <= 1'b0;
      s2_lanes <= '0;
      s2_data  <= '0;
    end else begin
      s1_rd    <= sel && wr_n;
      s1_lanes <= ~lane_n;
      s1_addr  <= addr;
      s2_rd    <= s1_rd;
      s2_lanes <= s1_lanes;
      s2_data  <= flow_data;
    end
  end

  assign out_rd    = pipe ? s2_rd    : s1_rd;
  assign out_lanes = pipe ? s2_lanes : s1_lanes;
  assign out_data  = pipe ? s2_data  : flow_data;

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign drive[l] = out_rd && out_lanes[l] && !oe_n;
    assign rdata[l*LANE_W +: LANE_W] =
      drive[l] ? out_data[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/tpram_top.sv
module tpram_top
  import tpram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_wr_n,
  input  logic [1:0]        a_lane_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [17:0]       a_wdata,
  output logic [17:0]       a_rdata,
  output logic [1:0]        a_drive,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_wr_n,
  input  logic [1:0]        b_lane_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [17:0]       b_wdata,
  output logic [17:0]       b_rdata,
  output logic [1:0]        b_drive
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]  clk_v, rst_v, csn_v, cs_v, wrn_v, oen_v, pipe_v;
  lane_t             lane_v  [NPORT];
  logic [ADDR_W-1:0] addr_v  [NPORT];
  word_t             wd_v    [NPORT];
  word_t             rd_v    [NPORT];
  lane_t             drv_v   [NPORT];
  lane_t             bwe     [NPORT];
  logic [ADDR_W-1:0] bwa     [NPORT];
  logic [ADDR_W-1:0] bra     [NPORT];
  word_t             bwd     [NPORT];
  word_t             own_rd  [NPORT];
  word_t             peer_rd [NPORT];
  word_t             peer_wr [NPORT];

  assign clk_v  = {b_clk, a_clk};
  assign rst_v  = {b_rst_n, a_rst_n};
  assign csn_v  = {b_cs_n, a_cs_n};
  assign cs_v   = {b_cs, a_cs};
  assign wrn_v  = {b_wr_n, a_wr_n};
  assign oen_v  = {b_oe_n, a_oe_n};
  assign pipe_v = {b_pipe, a_pipe};
  assign lane_v[0] = a_lane_n;
  assign lane_v[1] = b_lane_n;
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;
  assign wd_v[0]   = a_wdata;
  assign wd_v[1]   = b_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int Q = NPORT - 1 - p;

    tpram_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk        (clk_v[p]),
      .we         (bwe[p]),
      .waddr      (bwa[p]),
      .wdata      (bwd[p]),
      .self_raddr (bra[p]),
      .peer_raddr (bra[Q]),
      .peer_waddr (bwa[Q]),
      .self_q     (own_rd[p]),
      .peer_q     (peer_rd[Q]),
      .peer_wq    (peer_wr[Q])
    );

    tpram_port #(.ADDR_W(ADDR_W)) u_port (
      .clk        (clk_v[p]),
      .rst_n      (rst_v[p]),
      .cs_n       (csn_v[p]),
      .cs         (cs_v[p]),
      .wr_n       (wrn_v[p]),
      .lane_n     (lane_v[p]),
      .oe_n       (oen_v[p]),
      .pipe       (pipe_v[p]),
      .addr       (addr_v[p]),
      .wdata      (wd_v[p]),
      .own_at_rd  (own_rd[p]),
      .peer_at_rd (peer_rd[p]),
      .peer_at_wr (peer_wr[p]),
      .bank_we    (bwe[p]),
      .bank_waddr (bwa[p]),
      .bank_wdata (bwd[p]),
      .rd_addr    (bra[p]),
      .rdata      (rd_v[p]),
      .drive      (drv_v[p])
    );
  end

  assign a_rdata = rd_v[0];
  assign a_drive = drv_v[0];
  assign b_rdata = rd_v[1];
  assign b_drive = drv_v[1];
endmodule

// File: rtl/tpram_chk.sv
module tpram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        cs,
  input logic        wr_n,
  input logic [1:0]  lane_n,
  input logic        oe_n,
  input logic        pipe,
  input logic [17:0] rdata,
  input logic [1:0]  drive
);
  logic sel;
  assign sel = !cs_n && cs;

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> drive == 2'b00);

  // R4
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!drive[0] -> rdata[8:0] == '0) && (!drive[1] -> rdata[17:9] == '0)));

  // R5
  flow_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && $past(!pipe) && drive != 2'b00) |-> $past(sel && wr_n));

  // R4
  flow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && $past(!pipe) && drive != 2'b00) |-> (drive & $past(lane_n)) == 2'b00);

  // R7
  pipe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && $past(pipe) && $past(pipe, 2) && drive != 2'b00)
      |-> $past(sel && wr_n, 2));

  // R8
  reactivate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && !sel) |=> ##1 (!pipe || drive == 2'b00));
endmodule

bind tpram_top tpram_chk u_chk_a (
  .clk(a_clk), .rst_n(a_rst_n), .cs_n(a_cs_n), .cs(a_cs), .wr_n(a_wr_n),
  .lane_n(a_lane_n), .oe_n(a_oe_n), .pipe(a_pipe), .rdata(a_rdata), .drive(a_drive)
);

bind tpram_top tpram_chk u_chk_b (
  .clk(b_clk), .rst_n(b_rst_n), .cs_n(b_cs_n), .cs(b_cs), .wr_n(b_wr_n),
  .lane_n(b_lane_n), .oe_n(b_oe_n), .pipe(b_pipe), .rdata(b_rdata), .drive(b_drive)
);

// File: tb/tpram_top_bench.sv
module tpram_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_HALF     = (CLK_PERIOD * 7) / 10;
  localparam int ADDR_W     = 12;
  localparam int DEPTH      = 1 << ADDR_W;

  logic a_clk = 0, b_clk = 0;
  logic a_rst_n, b_rst_n;
  logic a_cs_n, a_cs, a_wr_n, a_oe_n, a_pipe;
  logic b_cs_n, b_cs, b_wr_n, b_oe_n, b_pipe;
  logic [1:0] a_lane_n, b_lane_n, a_drive, b_drive;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [17:0] a_wdata, b_wdata, a_rdata, b_rdata;

  logic [17:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) a_clk = ~a_clk;
  always #(B_HALF) b_clk = ~b_clk;

  tpram_top #(.ADDR_W(ADDR_W)) u_tpram_top (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_cs_n(a_cs_n), .a_cs(a_cs),
    .a_wr_n(a_wr_n), .a_lane_n(a_lane_n), .a_oe_n(a_oe_n), .a_pipe(a_pipe),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_cs_n(b_cs_n), .b_cs(b_cs),
    .b_wr_n(b_wr_n), .b_lane_n(b_lane_n), .b_oe_n(b_oe_n), .b_pipe(b_pipe),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wneg(input int p);
    if (p == 0) @(negedge a_clk); else @(negedge b_clk);
  endtask

  task automatic wpos(input int p);
    if (p == 0) @(posedge a_clk); else @(posedge b_clk);
  endtask

  task automatic drv_port(input int p, input logic csn, input logic cse, input logic wrn,
                          input logic [1:0] ln, input logic [ADDR_W-1:0] ad,
                          input logic [17:0] wd);
    if (p == 0) begin
      a_cs_n = csn; a_cs = cse; a_wr_n = wrn; a_lane_n = ln; a_addr = ad; a_wdata = wd;
    end else begin
      b_cs_n = csn; b_cs = cse; b_wr_n = wrn; b_lane_n = ln; b_addr = ad; b_wdata = wd;
    end
  endtask

  task automatic idle(input int p);
    drv_port(p, 1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
  endtask

  function automatic logic [17:0] rd(input int p);
    return (p == 0) ? a_rdata : b_rdata;
  endfunction

  function automatic logic [1:0] dv(input int p);
    return (p == 0) ? a_drive : b_drive;
  endfunction

  function automatic logic [17:0] lane_mask(input logic [1:0] en);
    return {{9{en[1]}}, {9{en[0]}}};
  endfunction

  task automatic set_mode(input int p, input logic pp, input logic oen);
    if (p == 0) begin a_pipe = pp; a_oe_n = oen; end
    else begin b_pipe = pp; b_oe_n = oen; end
  endtask

  task automatic write_word(input int p, input logic [ADDR_W-1:0] ad,
                            input logic [17:0] d, input logic [1:0] ln);
    wneg(p);
    drv_port(p, 1'b0, 1'b1, 1'b0, ln, ad, d);
    wpos(p);
    wneg(p);
    idle(p);
    model[ad] = (model[ad] & ~lane_mask(~ln)) | (d & lane_mask(~ln));
  endtask

  // One read with full timing checks for the port's current mode.
  task automatic read_word(input int p, input logic [ADDR_W-1:0] ad,
                           input logic [1:0] ln, input string req);
    logic pp, oen;
    logic [1:0]  edrv;
    logic [17:0] edat;
    pp   = (p == 0) ? a_pipe : b_pipe;
    oen  = (p == 0) ? a_oe_n : b_oe_n;
    edrv = oen ? 2'b00 : ~ln;
    edat = model[ad] & lane_mask(edrv);
    wneg(p);
    drv_port(p, 1'b0, 1'b1, 1'b1, ln, ad, ~model[ad]);
    wpos(p);
    wneg(p);
    idle(p);
    if (pp) begin
      check({req, " R7 drive early"}, {16'd0, dv(p)}, 18'd0);
      wpos(p);
      wneg(p);
    end
    check({req, " drive"}, {16'd0, dv(p)}, {16'd0, edrv});
    check({req, " data"}, rd(p), edat);
    if (!pp) begin
      wpos(p);
      wneg(p);
      check({req, " R6 one cycle"}, {16'd0, dv(p)}, 18'd0);
    end
  endtask

  task automatic t_reset;
    wneg(0);
    check("R11 a drive", {16'd0, a_drive}, 18'd0);
    check("R11 a data", a_rdata, 18'd0);
    wneg(1);
    check("R11 b drive", {16'd0, b_drive}, 18'd0);
    check("R11 b data", b_rdata, 18'd0);
  endtask

  task automatic t_basic;
    set_mode(0, 1'b0, 1'b0);
    set_mode(1, 1'b0, 1'b0);
    write_word(0, 12'h010, 18'h2A5A5, 2'b00);
    write_word(0, 12'h011, 18'h15A5A, 2'b00);
    read_word(0, 12'h010, 2'b00, "R1 a-self");
    read_word(1, 12'h011, 2'b00, "R1 b-cross");
    write_word(1, 12'h020, 18'h3FFFF, 2'b00);
    read_word(0, 12'h020, 2'b00, "R1 a-cross");
    read_word(0, 12'h010, 2'b00, "R3 read keeps word");
  endtask

  task automatic t_lanes;
    write_word(0, 12'h030, 18'h00000, 2'b00);
    write_word(0, 12'h030, 18'h3FFFF, 2'b10);
    read_word(0, 12'h030, 2'b00, "R2 lower only");
    write_word(1, 12'h030, 18'h2AAAA, 2'b01);
    read_word(1, 12'h030, 2'b00, "R2 upper only");
    write_word(0, 12'h030, 18'h12345, 2'b11);
    read_word(0, 12'h030, 2'b00, "R2 no lane");
  endtask

  task automatic t_oe;
    set_mode(0, 1'b0, 1'b1);
    read_word(0, 12'h010, 2'b00, "R4 oe off");
    set_mode(0, 1'b0, 1'b0);
    read_word(0, 12'h010, 2'b10, "R4 lower lane");
    read_word(0, 12'h010, 2'b01, "R4 upper lane");
  endtask

  task automatic t_select;
    logic [1:0] bad [3];
    bad[0] = 2'b11; bad[1] = 2'b00; bad[2] = 2'b10;
    for (int i = 0; i < 3; i++) begin
      wneg(0);
      drv_port(0, bad[i][1], bad[i][0], 1'b0, 2'b00, 12'h010, 18'h0F0F0);
      wpos(0);
      wneg(0);
      check("R5 deselected no read", {16'd0, a_drive}, 18'd0);
      drv_port(0, bad[i][1], bad[i][0], 1'b1, 2'b00, 12'h010, 18'h0);
      wpos(0);
      wneg(0);
      check("R5 deselected read no drive", {16'd0, a_drive}, 18'd0);
      idle(0);
    end
    read_word(1, 12'h010, 2'b00, "R5 deselected write ignored");
  endtask

  task automatic t_pipe;
    set_mode(1, 1'b1, 1'b0);
    read_word(1, 12'h011, 2'b00, "R7 pipe read");
    read_word(1, 12'h030, 2'b10, "R7 pipe lower");
    wneg(1);
    drv_port(1, 1'b0, 1'b1, 1'b1, 2'b00, 12'h010, '0);
    wpos(1); wneg(1);
    idle(1);
    wpos(1); wneg(1);
    check("R8 first read data", b_rdata, model[12'h010]);
    drv_port(1, 1'b0, 1'b1, 1'b1, 2'b00, 12'h020, '0);
    wpos(1); wneg(1);
    check("R8 gap after deselect", {16'd0, b_drive}, 18'd0);
    idle(1);
    wpos(1); wneg(1);
    check("R8 reactivated drive", {16'd0, b_drive}, 18'h3);
    check("R8 reactivated data", b_rdata, model[12'h020]);
    set_mode(1, 1'b0, 1'b0);
  endtask

  task automatic t_concurrent;
    fork
      for (int i = 0; i < 24; i++)
        write_word(0, ADDR_W'((i * 74 + 2) % DEPTH), 18'(i * 5381 + 7), 2'b00);
      for (int i = 0; i < 24; i++)
        write_word(1, ADDR_W'((i * 74 + 3) % DEPTH), 18'(i * 9973 + 11), 2'b00);
    join
    fork
      write_word(0, '0, 18'h1D2E3, 2'b00);
      write_word(1, ADDR_W'(DEPTH - 1), 18'h2C4B6, 2'b00);
    join
    for (int i = 0; i < 24; i += 5) begin
      read_word(1, ADDR_W'((i * 74 + 2) % DEPTH), 2'b00, "R10 b reads a");
      read_word(0, ADDR_W'((i * 74 + 3) % DEPTH), 2'b00, "R10 a reads b");
    end
    set_mode(0, 1'b1, 1'b0);
    read_word(0, ADDR_W'(DEPTH - 1), 2'b00, "R9 last address");
    read_word(1, '0, 2'b00, "R9 first address");
    fork
      read_word(0, 12'h020, 2'b00, "R1 same addr a");
      read_word(1, 12'h020, 2'b00, "R1 same addr b");
    join
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    a_rst_n = 0; b_rst_n = 0;
    idle(0); idle(1);
    set_mode(0, 1'b0, 1'b0);
    set_mode(1, 1'b0, 1'b0);
    repeat (4) @(posedge b_clk);
    t_reset;
    @(negedge a_clk); a_rst_n = 1;
    @(negedge b_clk); b_rst_n = 1;
    t_reset;
    t_basic;
    t_lanes;
    t_oe;
    t_select;
    t_pipe;
    t_concurrent;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge a_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule